// File: doc/BRIEF.md
# Waveform Sample RAM Bus Controller

This block owns the address, data and control lines of the fast sample RAM in a direct digital synthesizer. The RAM has two users. After power-up the host processor copies a table of waveform samples, read from slow nonvolatile storage, into the RAM. Once the table is in place, the phase accumulator addresses the RAM on every clock and the samples read back feed the DAC.

A single mode line from the host selects the user. The line is synchronized inside the block. Every change of owner passes through a guard cycle in which no RAM write can be issued. While the host owns the RAM, the DAC register sits at mid-scale so the analog output stays quiet. While the accumulator owns it, host write strobes are dropped. Sample delivery has a fixed pipeline latency, so the delay from phase to amplitude is known to the rest of the chain.

Top module: `wave_bus_ctrl`

## Requirements
- R1: Synchronous active-high reset selects the load state, drives `dac_out` to mid-scale (2^(DATA_W-1), 0x800 for 12 bits) and holds `ram_we` low.
- R2: `host_mode` (1 = synthesis, 0 = load) passes through a two-stage synchronizer. Each change of state passes through one guard cycle. A write strobe edge seen while the synchronized mode differs from the current load state, or during a guard cycle, issues no write.
- R3: In the load state, `ram_addr` takes `host_addr` one clock later. A rising edge of `host_wr` sampled on a clock issues exactly one `ram_we` pulse on the next clock, with `ram_wdata` equal to `host_wdata` from that sampling clock.
- R4: Holding `host_wr` high for several clocks produces a single write; `ram_we` is never high on two clocks in a row.
- R5: In the synthesis state and its guard cycles, host write strobes are ignored: `ram_we` stays low and the RAM contents are unchanged when later read back in the load state.
- R6: In the synthesis state, the value of `acc_addr` sampled on clock k addresses the RAM, and the sample stored there appears on `dac_out` after clock k+2.
- R7: When the state two clocks earlier was not synthesis (load state or either guard cycle), `dac_out` holds mid-scale.
- R8: `host_rdata` shows the RAM word at the `host_addr` sampled two clocks earlier while in the load state, so the host can verify the copied table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | Asynchronous owner select: 1 synthesis, 0 load |
| host_addr | input | ADDR_W | Host RAM address |
| host_wdata | input | DATA_W | Host write data |
| host_wr | input | 1 | Host write strobe, acted on at its rising edge |
| host_rdata | output | DATA_W | Registered RAM read data for the host |
| acc_addr | input | ADDR_W | Phase accumulator address (upper phase bits) |
| ram_addr | output | ADDR_W | RAM address |
| ram_wdata | output | DATA_W | RAM write data |
| ram_we | output | 1 | RAM write enable, one clock per write |
| ram_rdata | input | DATA_W | Asynchronous RAM read data |
| dac_out | output | DATA_W | DAC sample register |

## Verification
The hardest case to reach is a host write strobe that lands within a few clocks of a mode change. In that window, whether the write is kept depends on where the edge falls relative to the synchronizer and the guard cycle. The stimulus sweeps the offset between the mode edge and the strobe edge in both directions, load to synthesis and synthesis to load. The reference model decides cycle by cycle whether a write pulse is due, and the touched addresses are read back afterwards.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    typedef enum logic [1:0] {
        ST_LOAD    = 2'd0,
        ST_TO_SYN  = 2'd1,
        ST_SYN     = 2'd2,
        ST_TO_LOAD = 2'd3
    } bus_state_e;

    function automatic bus_state_e step_state(bus_state_e cur, logic want_syn);
        bus_state_e nxt;
        case (cur)
            ST_LOAD:    nxt = want_syn ? ST_TO_SYN : ST_LOAD;
            ST_TO_SYN:  nxt = ST_SYN;
            ST_SYN:     nxt = want_syn ? ST_SYN : ST_TO_LOAD;
            default:    nxt = ST_LOAD;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/wbc_mode_ctrl.sv
module wbc_mode_ctrl
    import wbc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_async,
    output logic       mode_sync,
    output bus_state_e state
);

    logic [SYNC_STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
            state <= ST_LOAD;
        end else begin
            chain <= {chain[SYNC_STAGES-2:0], mode_async};
            state <= step_state(state, chain[SYNC_STAGES-1]);
        end
    end

    assign mode_sync = chain[SYNC_STAGES-1];

    // R2
    guard_before_syn_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SYN) |-> ($past(state) == ST_SYN || $past(state) == ST_TO_SYN));

    // R2
    guard_before_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD) |-> ($past(state) == ST_LOAD || $past(state) == ST_TO_LOAD));

endmodule

// File: rtl/wbc_host_wr.sv
module wbc_host_wr #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_ok,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data
);

    logic wr_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_prev <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
        end else begin
            wr_prev <= host_wr;
            wr_en   <= load_ok && host_wr && !wr_prev;
            wr_data <= host_wdata;
        end
    end

    // R4
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !wr_en);

    // R3
    strobe_edge_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(host_wr));

endmodule

// File: rtl/wbc_read_pipe.sv
module wbc_read_pipe #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              syn_sel,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] dac_out
);

    localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

    logic v_addr, v_data;

    always_ff @(posedge clk) begin
        if (rst) begin
            ram_addr <= '0;
            rd_data  <= '0;
            dac_out  <= MID;
            v_addr   <= 1'b0;
            v_data   <= 1'b0;
        end else begin
            ram_addr <= syn_sel ? acc_addr : host_addr;
            v_addr   <= syn_sel;
            rd_data  <= ram_rdata;
            v_data   <= v_addr;
            dac_out  <= v_data ? rd_data : MID;
        end
    end

    // R6
    acc_drives_ram_chk: assert property (@(posedge clk) disable iff (rst)
        syn_sel |=> (ram_addr == $past(acc_addr)));

    // R7
    quiet_dac_chk: assert property (@(posedge clk) disable iff (rst)
        (!syn_sel && !$past(syn_sel) && !$past(syn_sel, 2)) |=> (dac_out == MID));

endmodule

// File: rtl/wave_bus_ctrl.sv
module wave_bus_ctrl
    import wbc_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_mode,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_wr,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              ram_we,
    input  logic [DATA_W-1:0] ram_rdata,
    output logic [DATA_W-1:0] dac_out
);

    bus_state_e state;
    logic       mode_sync;
    logic       load_ok;
    logic       syn_sel;

    wbc_mode_ctrl #(.SYNC_STAGES(2)) u_mode (
        .clk        (clk),
        .rst        (rst),
        .mode_async (host_mode),
        .mode_sync  (mode_sync),
        .state      (state)
    );

    assign load_ok = (state == ST_LOAD) && !mode_sync;
    assign syn_sel = (state == ST_SYN);

    wbc_host_wr #(.DATA_W(DATA_W)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .load_ok    (load_ok),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .wr_en      (ram_we),
        .wr_data    (ram_wdata)
    );

    wbc_read_pipe #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pipe (
        .clk       (clk),
        .rst       (rst),
        .syn_sel   (syn_sel),
        .acc_addr  (acc_addr),
        .host_addr (host_addr),
        .ram_rdata (ram_rdata),
        .ram_addr  (ram_addr),
        .rd_data   (host_rdata),
        .dac_out   (dac_out)
    );

    // R5
    no_write_in_syn_chk: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (state == ST_LOAD));

    // R2
    no_write_after_guard_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_TO_LOAD) |=> !ram_we);

endmodule

// File: tb/wave_bus_ctrl_tb.sv
module wave_bus_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DW = 12;
    localparam int DEPTH = 1 << AW;
    localparam logic [DW-1:0] MID = 12'h800;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_mode = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [DW-1:0] host_wdata = '0;
    logic          host_wr = 1'b0;
    logic [DW-1:0] host_rdata;
    logic [AW-1:0] acc_addr = '0;
    logic [AW-1:0] ram_addr;
    logic [DW-1:0] ram_wdata;
    logic          ram_we;
    logic [DW-1:0] ram_rdata;
    logic [DW-1:0] dac_out;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wave_bus_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst(rst), .host_mode(host_mode), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_wr(host_wr), .host_rdata(host_rdata),
        .acc_addr(acc_addr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_we(ram_we), .ram_rdata(ram_rdata), .dac_out(dac_out)
    );

    // external RAM
    logic [DW-1:0] ram [0:DEPTH-1];
    always @(posedge clk) if (ram_we) ram[ram_addr] <= ram_wdata;
    assign ram_rdata = ram[ram_addr];

    // reference model
    logic [DW-1:0] exp_mem [0:DEPTH-1];
    int  m_st = 0;
    bit  m_s1 = 0, m_s2 = 0, m_wrp = 0;
    bit  q_v[$];
    int  q_a[$];
    logic [DW-1:0] dac_exp = MID;
    bit  we_exp = 0;
    int  writes_seen = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_s1 = 0; m_s2 = 0; m_wrp = 0;
            q_v.delete(); q_a.delete();
            dac_exp = MID; we_exp = 0;
        end else begin
            we_exp = (m_st == 0) && !m_s2 && host_wr && !m_wrp;
            if (we_exp) exp_mem[host_addr] = host_wdata;
            q_v.push_back(m_st == 2);
            q_a.push_back(int'(acc_addr));
            if (q_v.size() > 2) begin
                bit v; int a;
                v = q_v.pop_front();
                a = q_a.pop_front();
                dac_exp = v ? exp_mem[a] : MID;
            end
            case (m_st)
                0: if (m_s2) m_st = 1;
                1: m_st = 2;
                2: if (!m_s2) m_st = 3;
                default: m_st = 0;
            endcase
            m_wrp = host_wr;
            m_s2 = m_s1;
            m_s1 = host_mode;
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle compare away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (ram_we) writes_seen++;
            check(dac_out == dac_exp, (m_st == 2) ? "R6 dac" : "R7 dac", dac_out, dac_exp);
            check(ram_we == we_exp, "R3/R5 ram_we", ram_we, we_exp);
        end
    end

    task automatic host_write(int a, int d);
        @(negedge clk);
        host_addr = AW'(a); host_wdata = DW'(d); host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic read_back(int a, string tag);
        @(negedge clk);
        host_addr = AW'(a);
        repeat (3) @(negedge clk);
        check(host_rdata == exp_mem[a], tag, host_rdata, exp_mem[a]);
    endtask

    task automatic run_synth(int k, int cycles);
        logic [31:0] phase = '0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            phase = phase + 32'(k);
            acc_addr = phase[31:32-AW];
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) begin ram[i] = '0; exp_mem[i] = '0; end
        repeat (4) @(negedge clk);
        // R1 reset state
        check(dac_out == MID, "R1 dac reset", dac_out, MID);
        check(ram_we == 1'b0, "R1 we reset", ram_we, 0);
        rst = 1'b0;

        // R3 load full table
        for (int a = 0; a < DEPTH; a++) host_write(a, (a * 37 + 5) & 12'hfff);
        // R8 readback
        read_back(0, "R8 readback");
        read_back(513, "R8 readback");
        read_back(DEPTH - 1, "R8 readback");

        // R4 held strobe: exactly one write
        writes_seen = 0;
        @(negedge clk);
        host_addr = 10'd7; host_wdata = 12'hABC; host_wr = 1'b1;
        repeat (5) @(negedge clk);
        host_wdata = 12'h123;
        repeat (2) @(negedge clk);
        host_wr = 1'b0;
        repeat (2) @(negedge clk);
        check(writes_seen == 1, "R4 held strobe count", writes_seen, 1);
        read_back(7, "R4 held strobe data");

        // R6 synthesis with several tuning words
        host_mode = 1'b1;
        run_synth(32'h0040_0000, 300);
        run_synth(32'h0123_4567, 300);
        run_synth(32'h7FFF_FFFF, 200);
        // R5 strobes during synthesis ignored
        writes_seen = 0;
        for (int i = 0; i < 4; i++) host_write(20 + i, 12'hFFF);
        repeat (3) @(negedge clk);
        check(writes_seen == 0, "R5 synth writes", writes_seen, 0);
        host_mode = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < 4; i++) read_back(20 + i, "R5 contents kept");

        // R2 strobes near mode edges, both directions
        for (int off = 0; off < 6; off++) begin
            @(negedge clk);
            host_mode = 1'b1;
            repeat (off) @(negedge clk);
            host_write(100 + off, 12'h300 + off);
            run_synth(32'h0200_0000, 10);
            host_mode = 1'b0;
            repeat (off) @(negedge clk);
            host_write(200 + off, 12'h500 + off);
            repeat (10) @(negedge clk);
        end
        for (int off = 0; off < 6; off++) begin
            read_back(100 + off, "R2 edge write load->syn");
            read_back(200 + off, "R2 edge write syn->load");
        end

        // R7 back in load: DAC stays quiet
        repeat (5) @(negedge clk);
        check(dac_out == MID, "R7 quiet in load", dac_out, MID);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule